// File: doc/BRIEF.md
# Two-Wire Debug Frame Master

This block is the master side of a two-wire programming and debug link. It drives one clock line and one bidirectional data line, the latter with its own output enable. On the host side it has a small command port with a valid/ready handshake. Each accepted command is one complete frame, bit by bit from the start strobe to the stop strobe. The four frame kinds are address write, address read, data write and data read. When the frame ends, the block gives a single-cycle done pulse together with an error flag and the last byte it captured.

Every clock pulse on the link is a short high-low-high strobe. Its low and high times come from a cycle counter on the system clock, and each time is given in nanoseconds together with the system clock frequency. A long low pulse resets the target, and the block produces one on request. Data frames contain a wait field: the target holds the data line low until it is ready. The master keeps strobing through this field and gives up after a bounded number of strobes. Link access has to be enabled before any frame or reset runs. Access changes only while the block is idle, so the clock line is already high when it starts being driven.

Top module: `twd_frame_master`

## Requirements
- R1: After reset the clock output is high, both output enables are low, done_o is low and cmd_ready_o is low.
- R2: The clock enable follows access_en_i, and it changes only while no frame or target reset is running. When it rises, the clock output is already high and the data line is released. While access is off, cmd_ready_o stays low and commands and reset requests produce no strobe and no done pulse.
- R3: Every frame strobe holds the clock low for exactly LOW_CYC system cycles, where LOW_CYC = CLK_MHZ*LOW_NS/1000. Between strobes of a frame the clock stays high for at least HIGH_CYC system cycles.
- R4: A reset request accepted while idle holds the clock low for exactly RST_CYC = CLK_MHZ*RESET_NS/1000 cycles, returns it high, and then pulses done_o with err_o low and rdata_o unchanged.
- R5: Each frame starts with one strobe with the data line released. Next comes a 2-bit instruction field driven LSB first, equal to cmd_op_i: 2'b11 address write, 2'b10 address read, 2'b01 data write, 2'b00 data read.
- R6: An address write drives cmd_data_i LSB first over 8 strobes, then gives one released stop strobe, for 12 strobes in total.
- R7: An address read samples the data line after each of 8 released strobes and shifts each bit in at the MSB end, so the first bit lands in bit 0. After the stop strobe the byte appears on rdata_o (12 strobes).
- R8: A data write drives a length field of two zero bits after the instruction, then the 8 data bits LSB first, then the wait field, then the stop strobe.
- R9: A data read drives the zero length field, then the wait field, then samples 8 bits LSB first, then gives the stop strobe. The byte appears on rdata_o.
- R10: The wait field strobes with the line released until a sample reads high. It succeeds if that happens on strobe number WAIT_LIMIT or earlier. Otherwise the frame ends after WAIT_LIMIT wait strobes with no stop strobe, and with err_o high.
- R11: done_o is high for exactly one cycle per frame or reset. rdata_o changes only in a cycle where done_o is high, and only after a read frame that succeeded.
- R12: cmd_ready_o is low from the cycle after a command is accepted until done_o. While it is low, cmd_valid_i and rst_req_i have no effect.
- R13: The data output enable is high only during instruction, length and write-byte strobes. The data line and its enable change only on the system edge that starts a strobe's low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| access_en_i | input | 1 | Request to take control of the link |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Command accepted on this edge when valid is also high |
| cmd_op_i | input | 2 | Frame kind, equal to the instruction code |
| cmd_data_i | input | 8 | Address or data byte for write frames |
| rst_req_i | input | 1 | Request a target reset pulse |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| err_o | output | 1 | Wait-field timeout, valid with done_o |
| rdata_o | output | 8 | Last byte captured by a successful read |
| tw_clk_o | output | 1 | Link clock value |
| tw_clk_oe_o | output | 1 | Link clock drive enable |
| tw_dat_o | output | 1 | Link data value |
| tw_dat_oe_o | output | 1 | Link data drive enable |
| tw_dat_i | input | 1 | Link data as seen at the pin |

## Verification
A wrong field counter or a wrong field transition shows up within one strobe as a wrong strobe count, a drive window in the wrong place, or a bit out of order in the per-strobe log. Those effects appear before done_o. A fault in the wait-field count appears as a timeout that comes too early or too late, at exactly the WAIT_LIMIT boundary. A wrong timing counter shows up on the first low phase as a wrong width, measured in system cycles. A shift-direction fault shows up on rdata_o when the frame completes.

// File: rtl/twd_pkg.sv
package twd_pkg;
  // Instruction codes as sent on the wire
  typedef enum logic [1:0] {
    OP_DRD = 2'b00,
    OP_DWR = 2'b01,
    OP_ARD = 2'b10,
    OP_AWR = 2'b11
  } twd_op_e;

  typedef enum logic [2:0] {
    F_START, F_INS, F_LEN, F_WBYTE, F_WAIT, F_RBYTE, F_STOP
  } twd_field_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_ISSUE, ST_STROBE
  } twd_state_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_LOW, PH_HIGH
  } twd_phase_e;
endpackage

// File: rtl/twd_strobe_gen.sv
module twd_strobe_gen
  import twd_pkg::*;
#(
  parameter int unsigned LOW_CYC  = 250,
  parameter int unsigned HIGH_CYC = 250,
  parameter int unsigned RST_CYC  = 6250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic long_i,
  output logic line_o,
  output logic idle_o,
  output logic done_o
);
  localparam int unsigned MAX_LH  = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int unsigned MAX_CYC = (RST_CYC > MAX_LH) ? RST_CYC : MAX_LH;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  twd_phase_e    phase_q;
  logic [CW-1:0] cnt_q;
  logic          line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      line_q  <= 1'b1;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (go_i) begin
          line_q  <= 1'b0;
          phase_q <= PH_LOW;
          cnt_q   <= long_i ? CW'(RST_CYC - 1) : CW'(LOW_CYC - 1);
        end
        PH_LOW: if (cnt_q == '0) begin
          line_q  <= 1'b1;
          phase_q <= PH_HIGH;
          cnt_q   <= CW'(HIGH_CYC - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        PH_HIGH: if (cnt_q == '0) begin
          phase_q <= PH_IDLE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign line_o = line_q;
  assign idle_o = (phase_q == PH_IDLE);
  assign done_o = (phase_q == PH_HIGH) && (cnt_q == '0);

  // low-phase length seen on the line, for checking only
  logic [CW:0] low_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      low_len_q <= '0;
    else if (!line_q) low_len_q <= low_len_q + 1'b1;
    else              low_len_q <= '0;
  end

  // R3
  go_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> phase_q == PH_IDLE);

  // R3 R4
  low_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_q) |-> (low_len_q == (CW+1)'(LOW_CYC)) || (low_len_q == (CW+1)'(RST_CYC)));
endmodule

// File: rtl/twd_frame_seq.sv
module twd_frame_seq
  import twd_pkg::*;
#(
  parameter int unsigned WAIT_LIMIT = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       access_i,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_op_i,
  input  logic [7:0] cmd_data_i,
  input  logic       rst_req_i,
  input  logic       dat_i,
  input  logic       strb_done_i,
  output logic       cmd_ready_o,
  output logic       idle_o,
  output logic       go_o,
  output logic       long_o,
  output logic       dat_o,
  output logic       dat_oe_o,
  output logic       done_o,
  output logic       err_o,
  output logic [7:0] rdata_o
);
  localparam int unsigned WCW = $clog2(WAIT_LIMIT + 1);

  twd_state_e     state_q;
  twd_field_e     field_q;
  twd_op_e        op_q;
  logic [7:0]     wbyte_q, rbyte_q, rdata_q;
  logic [2:0]     bit_q;
  logic [WCW-1:0] wait_q;
  logic           is_rst_q, dat_q, oe_q, done_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      field_q  <= F_START;
      op_q     <= OP_DRD;
      wbyte_q  <= '0;
      rbyte_q  <= '0;
      rdata_q  <= '0;
      bit_q    <= '0;
      wait_q   <= '0;
      is_rst_q <= 1'b0;
      dat_q    <= 1'b0;
      oe_q     <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (access_i) begin
          if (rst_req_i) begin
            is_rst_q <= 1'b1;
            state_q  <= ST_ISSUE;
          end else if (cmd_valid_i) begin
            op_q     <= twd_op_e'(cmd_op_i);
            wbyte_q  <= cmd_data_i;
            field_q  <= F_START;
            bit_q    <= '0;
            wait_q   <= '0;
            is_rst_q <= 1'b0;
            state_q  <= ST_ISSUE;
          end
        end
        // drive settings change on the same edge the clock falls
        ST_ISSUE: begin
          state_q <= ST_STROBE;
          oe_q    <= 1'b0;
          dat_q   <= 1'b0;
          if (!is_rst_q) begin
            unique case (field_q)
              F_INS:   begin oe_q <= 1'b1; dat_q <= op_q[bit_q[0]]; end
              F_LEN:   oe_q <= 1'b1;
              F_WBYTE: begin oe_q <= 1'b1; dat_q <= wbyte_q[bit_q]; end
              default: ;
            endcase
          end
        end
        ST_STROBE: if (strb_done_i) begin
          state_q <= ST_ISSUE;
          if (is_rst_q) begin
            is_rst_q <= 1'b0;
            done_q   <= 1'b1;
            err_q    <= 1'b0;
            state_q  <= ST_IDLE;
          end else begin
            unique case (field_q)
              F_START: begin field_q <= F_INS; bit_q <= '0; end
              F_INS: if (bit_q[0]) begin
                bit_q <= '0;
                if (!op_q[1])     field_q <= F_LEN;
                else if (op_q[0]) field_q <= F_WBYTE;
                else              field_q <= F_RBYTE;
              end else bit_q <= bit_q + 1'b1;
              F_LEN: if (bit_q[0]) begin
                bit_q   <= '0;
                field_q <= op_q[0] ? F_WBYTE : F_WAIT;
              end else bit_q <= bit_q + 1'b1;
              F_WBYTE: if (bit_q == 3'd7) begin
                bit_q   <= '0;
                field_q <= op_q[1] ? F_STOP : F_WAIT;
              end else bit_q <= bit_q + 1'b1;
              F_WAIT: if (dat_i) begin
                bit_q   <= '0;
                field_q <= op_q[0] ? F_STOP : F_RBYTE;
              end else if (wait_q == WCW'(WAIT_LIMIT - 1)) begin
                done_q  <= 1'b1;
                err_q   <= 1'b1;
                state_q <= ST_IDLE;
              end else wait_q <= wait_q + 1'b1;
              F_RBYTE: begin
                rbyte_q <= {dat_i, rbyte_q[7:1]};
                if (bit_q == 3'd7) field_q <= F_STOP;
                else               bit_q <= bit_q + 1'b1;
              end
              F_STOP: begin
                done_q  <= 1'b1;
                err_q   <= 1'b0;
                state_q <= ST_IDLE;
                if (!op_q[0]) rdata_q <= rbyte_q;
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (state_q == ST_IDLE) && access_i;
  assign idle_o      = (state_q == ST_IDLE);
  assign go_o        = (state_q == ST_ISSUE);
  assign long_o      = is_rst_q;
  assign dat_o       = dat_q;
  assign dat_oe_o    = oe_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign rdata_o     = rdata_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> done_o);

  // R12
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

  // R13
  dat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STROBE) |=> $stable(dat_oe_o) && $stable(dat_o));

  // R10
  wait_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q < WCW'(WAIT_LIMIT));
endmodule

// File: rtl/twd_frame_master.sv
module twd_frame_master #(
  parameter int unsigned CLK_MHZ    = 250,
  parameter int unsigned LOW_NS     = 1000,
  parameter int unsigned HIGH_NS    = 1000,
  parameter int unsigned RESET_NS   = 25000,
  parameter int unsigned WAIT_LIMIT = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       access_en_i,
  input  logic       cmd_valid_i,
  output logic       cmd_ready_o,
  input  logic [1:0] cmd_op_i,
  input  logic [7:0] cmd_data_i,
  input  logic       rst_req_i,
  output logic       done_o,
  output logic       err_o,
  output logic [7:0] rdata_o,
  output logic       tw_clk_o,
  output logic       tw_clk_oe_o,
  output logic       tw_dat_o,
  output logic       tw_dat_oe_o,
  input  logic       tw_dat_i
);
  localparam int unsigned LOW_RAW  = CLK_MHZ * LOW_NS / 1000;
  localparam int unsigned HIGH_RAW = CLK_MHZ * HIGH_NS / 1000;
  localparam int unsigned RST_RAW  = CLK_MHZ * RESET_NS / 1000;
  localparam int unsigned LOW_CYC  = (LOW_RAW  == 0) ? 1 : LOW_RAW;
  localparam int unsigned HIGH_CYC = (HIGH_RAW == 0) ? 1 : HIGH_RAW;
  localparam int unsigned RST_CYC  = (RST_RAW  == 0) ? 1 : RST_RAW;

  logic access_q, seq_idle, gen_idle, go, long_pulse, strb_done, line, dat, dat_oe;

  // access switches only between operations, never mid-strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  access_q <= 1'b0;
    else if (seq_idle && gen_idle) access_q <= access_en_i;
  end

  twd_frame_seq #(.WAIT_LIMIT(WAIT_LIMIT)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .access_i    (access_q),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_data_i  (cmd_data_i),
    .rst_req_i   (rst_req_i),
    .dat_i       (tw_dat_i),
    .strb_done_i (strb_done),
    .cmd_ready_o (cmd_ready_o),
    .idle_o      (seq_idle),
    .go_o        (go),
    .long_o      (long_pulse),
    .dat_o       (dat),
    .dat_oe_o    (dat_oe),
    .done_o      (done_o),
    .err_o       (err_o),
    .rdata_o     (rdata_o)
  );

  twd_strobe_gen #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC), .RST_CYC(RST_CYC)) u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .long_i (long_pulse),
    .line_o (line),
    .idle_o (gen_idle),
    .done_o (strb_done)
  );

  assign tw_clk_o    = line;
  assign tw_clk_oe_o = access_q;
  assign tw_dat_o    = dat;
  assign tw_dat_oe_o = dat_oe & access_q;

  // R2
  clk_oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tw_clk_oe_o) |-> tw_clk_o && !tw_dat_oe_o);

  // R2
  access_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tw_clk_oe_o |-> !tw_dat_oe_o && tw_clk_o);
endmodule

// File: tb/twd_frame_master_bench.sv
module twd_frame_master_bench;
  localparam int WL   = 20;
  localparam int LOWC = 10;
  localparam int HIC  = 10;
  localparam int RSTC = 100;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] wb;
    logic [5:0] waits;
    logic [7:0] rb;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'b11, 8'hB4, 6'd0,  8'h00},
    '{2'b11, 8'h01, 6'd0,  8'h00},
    '{2'b10, 8'h00, 6'd0,  8'h5A},
    '{2'b01, 8'h02, 6'd0,  8'h00},
    '{2'b01, 8'hA5, 6'd3,  8'h00},
    '{2'b00, 8'h00, 6'd0,  8'hC3},
    '{2'b00, 8'h00, 6'd5,  8'h0D},
    '{2'b01, 8'h6E, 6'd19, 8'h00},
    '{2'b00, 8'h00, 6'd20, 8'h77},
    '{2'b01, 8'hDE, 6'd25, 8'h00},
    '{2'b10, 8'h00, 6'd0,  8'h80}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic access_en_i = 1'b0, cmd_valid_i = 1'b0, rst_req_i = 1'b0, tw_dat_i = 1'b0;
  logic [1:0] cmd_op_i = '0;
  logic [7:0] cmd_data_i = '0;
  logic cmd_ready_o, done_o, err_o, tw_clk_o, tw_clk_oe_o, tw_dat_o, tw_dat_oe_o;
  logic [7:0] rdata_o;

  always #2 clk = ~clk;

  twd_frame_master #(.CLK_MHZ(250), .LOW_NS(40), .HIGH_NS(40), .RESET_NS(400),
                     .WAIT_LIMIT(WL)) u_twd_frame_master (
    .clk_i(clk), .rst_ni(rst_ni), .access_en_i(access_en_i),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o), .cmd_op_i(cmd_op_i),
    .cmd_data_i(cmd_data_i), .rst_req_i(rst_req_i), .done_o(done_o), .err_o(err_o),
    .rdata_o(rdata_o), .tw_clk_o(tw_clk_o), .tw_clk_oe_o(tw_clk_oe_o),
    .tw_dat_o(tw_dat_o), .tw_dat_oe_o(tw_dat_oe_o), .tw_dat_i(tw_dat_i)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  int nr = 0, nf = 0;
  logic [63:0] oe_log = '0, val_log = '0;
  logic [1:0] cur_op = '0;
  logic [7:0] cur_rb = '0;
  int cur_waits = 0;
  int low_run = 0, high_run = 0, last_low = 0, min_low = 1000000, max_low = 0, min_high = 1000000;
  int done_cnt = 0, done_run = 0, max_done_run = 0;
  logic last_err = 1'b0;
  logic [7:0] last_rdata = '0;
  logic rise_clk = 1'b0, rise_oe = 1'b1;

  // target model: value offered on the data line for strobe idx
  function automatic logic resp(int idx);
    int ws;
    if (cur_op == 2'b10) return (idx >= 3 && idx <= 10) ? cur_rb[idx-3] : 1'b0;
    if (cur_op[1]) return 1'b0;
    ws = (cur_op == 2'b01) ? 13 : 5;
    if (idx >= ws && idx < ws + cur_waits) return 1'b0;
    if (idx == ws + cur_waits) return 1'b1;
    if (cur_op == 2'b00 && idx > ws + cur_waits && idx <= ws + cur_waits + 8)
      return cur_rb[idx - ws - cur_waits - 1];
    return 1'b0;
  endfunction

  always @(posedge tw_clk_o) if (nr < 64) begin
    oe_log[nr]  = tw_dat_oe_o;
    val_log[nr] = tw_dat_o;
    nr++;
  end

  always @(negedge tw_clk_o) begin
    tw_dat_i = resp(nf);
    nf++;
  end

  always @(posedge tw_clk_oe_o) begin
    rise_clk = tw_clk_o;
    rise_oe  = tw_dat_oe_o;
  end

  always @(negedge clk) begin
    if (!tw_clk_o) begin
      if (high_run > 0) begin
        if (high_run < min_high) min_high = high_run;
        high_run = 0;
      end
      low_run++;
    end else begin
      if (low_run > 0) begin
        last_low = low_run;
        if (low_run < min_low) min_low = low_run;
        if (low_run > max_low) max_low = low_run;
        low_run = 0;
      end
      high_run++;
    end
    if (done_o) begin
      done_cnt++;
      last_err   = err_o;
      last_rdata = rdata_o;
      done_run++;
      if (done_run > max_done_run) max_done_run = done_run;
    end else done_run = 0;
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue_cmd(logic [1:0] op, logic [7:0] d);
    int g = 0;
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_data_i = d;
    while (!cmd_ready_o && g < 1000) begin @(negedge clk); g++; end
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic wait_done(int d0);
    int g = 0;
    while (done_cnt == d0 && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic start_log(logic [1:0] op, logic [7:0] rb, int waits);
    cur_op = op; cur_rb = rb; cur_waits = waits;
    nr = 0; nf = 0; oe_log = '0; val_log = '0;
  endtask

  task automatic build_exp(logic [1:0] op, logic [7:0] wb, int waits,
                           output int en, output logic [63:0] eoe, output logic [63:0] eval);
    bit to = 0;
    en = 1; eoe = '0; eval = '0;
    for (int k = 0; k < 2; k++) begin eoe[en] = 1'b1; eval[en] = op[k]; en++; end
    if (!op[1]) for (int k = 0; k < 2; k++) begin eoe[en] = 1'b1; en++; end
    if (op[0]) for (int k = 0; k < 8; k++) begin eoe[en] = 1'b1; eval[en] = wb[k]; en++; end
    if (!op[1]) begin
      if (waits >= WL) begin en += WL; to = 1; end
      else en += waits + 1;
    end
    if (!to) begin
      if (!op[0]) en += 8;
      en++;
    end
  endtask

  function automatic string tag_of(logic [1:0] op, int waits);
    if (!op[1] && waits >= WL - 1) return "R10";
    case (op)
      2'b11: return "R6";
      2'b10: return "R7";
      2'b01: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int d0, en;
    logic [63:0] eoe, eval;
    logic [7:0] exp_rdata;
    bit exp_err;
    exp_rdata = 8'h00;

    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tw_clk_o == 1'b1,    "R1 clk", tw_clk_o, 1);
    chk(tw_clk_oe_o == 1'b0, "R1 clk_oe", tw_clk_oe_o, 0);
    chk(tw_dat_oe_o == 1'b0, "R1 dat_oe", tw_dat_oe_o, 0);
    chk(done_o == 1'b0,      "R1 done", done_o, 0);
    chk(cmd_ready_o == 1'b0, "R1 ready", cmd_ready_o, 0);

    // R2 access off: requests ignored
    start_log(2'b11, 8'h00, 0);
    d0 = done_cnt;
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = 2'b11; rst_req_i = 1'b1;
    repeat (20) @(negedge clk);
    chk(cmd_ready_o == 1'b0, "R2 ready while off", cmd_ready_o, 0);
    cmd_valid_i = 1'b0; rst_req_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(nf == 0, "R2 strobes while off", nf, 0);
    chk(done_cnt == d0, "R2 done while off", done_cnt, d0);

    // R2 access on
    access_en_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(tw_clk_oe_o == 1'b1, "R2 clk_oe", tw_clk_oe_o, 1);
    chk(rise_clk == 1'b1, "R2 clk high at enable", rise_clk, 1);
    chk(rise_oe == 1'b0, "R2 data released at enable", rise_oe, 0);
    chk(cmd_ready_o == 1'b1, "R2 ready", cmd_ready_o, 1);

    // vector table
    min_low = 1000000; max_low = 0; min_high = 1000000;
    for (int i = 0; i < NV; i++) begin
      start_log(VECS[i].op, VECS[i].rb, int'(VECS[i].waits));
      d0 = done_cnt;
      issue_cmd(VECS[i].op, VECS[i].wb);
      wait_done(d0);
      repeat (40) @(negedge clk);
      build_exp(VECS[i].op, VECS[i].wb, int'(VECS[i].waits), en, eoe, eval);
      exp_err = !VECS[i].op[1] && (int'(VECS[i].waits) >= WL);
      if (!VECS[i].op[0] && !exp_err) exp_rdata = VECS[i].rb;
      chk(nr == en, {tag_of(VECS[i].op, int'(VECS[i].waits)), " strobe count"}, nr, en);
      chk(oe_log == eoe, "R5 R13 drive window", oe_log, eoe);
      chk((val_log & eoe) == eval, "R5 driven bits", val_log & eoe, eval);
      chk(done_cnt == d0 + 1, "R11 one done", done_cnt, d0 + 1);
      chk(last_err == exp_err, {tag_of(VECS[i].op, int'(VECS[i].waits)), " err"}, last_err, exp_err);
      chk(rdata_o == exp_rdata, {tag_of(VECS[i].op, int'(VECS[i].waits)), " rdata"}, rdata_o, exp_rdata);
    end
    chk(min_low == LOWC && max_low == LOWC, "R3 low width", {max_low[31:0], min_low[31:0]}, {LOWC[31:0], LOWC[31:0]});
    chk(min_high >= HIC, "R3 high width", min_high, HIC);
    chk(max_done_run == 1, "R11 done width", max_done_run, 1);

    // R4 target reset
    start_log(2'b11, 8'h00, 0);
    d0 = done_cnt;
    @(negedge clk); rst_req_i = 1'b1;
    @(negedge clk); rst_req_i = 1'b0;
    wait_done(d0);
    repeat (3) @(negedge clk);
    chk(last_low == RSTC, "R4 reset low width", last_low, RSTC);
    chk(nf == 1, "R4 single pulse", nf, 1);
    chk(done_cnt == d0 + 1 && last_err == 1'b0, "R4 done no err", {done_cnt, last_err}, {d0 + 1, 1'b0});
    chk(rdata_o == exp_rdata, "R4 rdata kept", rdata_o, exp_rdata);

    // R12 requests during a frame are ignored
    start_log(2'b11, 8'h00, 0);
    d0 = done_cnt;
    issue_cmd(2'b11, 8'h3C);
    repeat (40) @(negedge clk);
    chk(cmd_ready_o == 1'b0, "R12 ready low when busy", cmd_ready_o, 0);
    cmd_valid_i = 1'b1; cmd_op_i = 2'b00; rst_req_i = 1'b1;
    repeat (30) @(negedge clk);
    cmd_valid_i = 1'b0; rst_req_i = 1'b0;
    wait_done(d0);
    repeat (300) @(negedge clk);
    build_exp(2'b11, 8'h3C, 0, en, eoe, eval);
    chk(nr == en, "R12 strobe count", nr, en);
    chk((val_log & eoe) == eval, "R12 bits", val_log & eoe, eval);
    chk(done_cnt == d0 + 1, "R12 single done", done_cnt, d0 + 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule